// File: doc/BRIEF.md
# Vectored Interrupt Manager with Channel Remapping

This block collects up to 96 level-sensitive interrupt request lines and presents them to a processor as two outputs: a normal interrupt and a fast interrupt. Priority is not stored as a number per source. Instead, each of 96 fixed-priority channels carries a programmable 7-bit request number. Channel 0 is the most urgent, and a lower channel number always beats a higher one. Software raises or lowers a source's priority by moving its request number to a different channel.

Each channel has an enable bit. Enable bits are changed through two write-one registers, one that sets bits and one that clears them. Channels 0 and 1 are permanently enabled. Each channel also has a class bit that sends it either to the fast output or to the normal output. An index register gives the winning normal-class channel plus one, and reads as zero when nothing is pending. Software reads it in a loop until it returns zero.

All state is reached through a single-cycle register port that uses word addresses. Read data comes back one cycle after the address is presented. Reading any register has no side effects.

Top module: `irq_vector_mgr`

Register map (word addresses, default parameters):
- `0x00`–`0x17`: channel map words. Word w holds channels 4w to 4w+3. Channel 4w+k is at bits `[30-8k:24-8k]`, so the lowest channel of a word is in the top byte. Bits 31, 23, 15 and 7 read as zero.
- `0x20`–`0x22`: enable set. `0x24`–`0x26`: enable clear. `0x28`–`0x2A`: fast-class select. `0x2C`–`0x2E`: pending status. In each of these, channel n is word n>>5, bit n&31.
- `0x30`: index.

## Requirements
- R1: After reset, channel c maps to request c, so map word 0 reads `0x00010203` and word 5 reads `0x14151617`. A map write stores the four 7-bit fields, and the unused bits 31, 23, 15 and 7 read back as 0.
- R2: Pending bit c is the level of request line `map[c]`. A map entry of 96 or more never produces a pending bit. Pending status is read at `0x2C`+word.
- R3: Writing 1s to an enable-set word enables those channels and leaves the other bits unchanged. After reset only channels 0 and 1 are enabled.
- R4: Writing 1s to an enable-clear word disables those channels. The set address and the clear address both read back the current enable state.
- R5: Channels 0 and 1 stay enabled, whatever is written to the clear register.
- R6: Fast-class select resets to 3 in word 0 and 0 elsewhere, and can be written. A fast-class channel never wins the index.
- R7: The index reads 0 when no enabled normal-class channel is pending. Otherwise it reads (lowest such channel)+1. It reflects a request change within two cycles, and read data follows the address by one cycle.
- R8: `irq_o` is high exactly when the registered index is nonzero.
- R9: `fiq_o` rises one cycle after any enabled fast-class channel is pending, and follows that condition with one cycle of delay.
- R10: Reading the index repeatedly returns the same value and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_REQ (96) | Level-sensitive request lines |
| reg_addr | input | 7 | Register word address |
| reg_we | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, one cycle after the address |
| irq_o | output | 1 | Normal interrupt, registered |
| fiq_o | output | 1 | Fast interrupt, registered |

## Verification
A corrupted map entry makes the pending bit appear in the wrong channel, and the index register shows the wrong winner within two cycles of the request. A lost or stuck enable bit or class bit has two visible effects. It makes the index skip a pending channel or report a disabled one. It also makes `irq_o` disagree with `fiq_o` for a lone request. Both show up by the next index read. Because the locked channels and the write-one semantics are read back through both enable addresses, a clear that reaches channels 0 or 1 is seen on the very next read.

// File: rtl/irq_vector_mgr_pkg.sv
package irq_vector_mgr_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 32;
  localparam int LANES      = 4;
  localparam int LOCKED_CH  = 2;
  // Word addresses of register groups (bit-vector groups span 4 slots each)
  localparam logic [ADDR_W-1:0] BASE_ENSET = 7'h20;
  localparam logic [ADDR_W-1:0] BASE_ENCLR = 7'h24;
  localparam logic [ADDR_W-1:0] BASE_FAST  = 7'h28;
  localparam logic [ADDR_W-1:0] BASE_PEND  = 7'h2C;
  localparam logic [ADDR_W-1:0] ADDR_INDEX = 7'h30;

  typedef enum logic [2:0] {
    GRP_MAP, GRP_ENSET, GRP_ENCLR, GRP_FAST, GRP_PEND, GRP_INDEX, GRP_NONE
  } reg_grp_e;

  function automatic reg_grp_e decode_grp(input logic [ADDR_W-1:0] a,
                                          input int map_words);
    if (int'(a) < map_words)          return GRP_MAP;
    else if (a[6:2] == BASE_ENSET[6:2]) return GRP_ENSET;
    else if (a[6:2] == BASE_ENCLR[6:2]) return GRP_ENCLR;
    else if (a[6:2] == BASE_FAST[6:2])  return GRP_FAST;
    else if (a[6:2] == BASE_PEND[6:2])  return GRP_PEND;
    else if (a == ADDR_INDEX)           return GRP_INDEX;
    else                                return GRP_NONE;
  endfunction
endpackage

// File: rtl/irq_map_table.sv
module irq_map_table
  import irq_vector_mgr_pkg::*;
#(
  parameter int NUM_CH  = 96,
  parameter int NUM_REQ = 96,
  parameter int REQ_W   = 7,
  localparam int MAP_WORDS = NUM_CH / LANES,
  localparam int MW_W      = $clog2(MAP_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MW_W-1:0]   word_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] pend_o
);
  logic [REQ_W-1:0] map_q [NUM_CH];

  // Lane k of a word sits at bit offset 24-8k
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) map_q[c] <= REQ_W'(c);
    end else if (wr_en) begin
      for (int k = 0; k < LANES; k++)
        map_q[int'(word_sel)*LANES + k] <= wr_data[24-8*k +: REQ_W];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < LANES; k++)
      rd_data[24-8*k +: REQ_W] = map_q[int'(word_sel)*LANES + k];
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
      assign pend_o[c] = (int'(map_q[c]) < NUM_REQ) ? req_i[map_q[c]] : 1'b0;
    end
  endgenerate

  logic unused_bits;
  assign unused_bits = ^{wr_data[31], wr_data[23], wr_data[15], wr_data[7]};
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_vector_mgr_pkg::*;
#(
  parameter int NUM_CH = 96,
  localparam int BIT_WORDS = NUM_CH / DATA_W,
  localparam int BW_W      = (BIT_WORDS > 1) ? $clog2(BIT_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              fast_we,
  input  logic [1:0]        word_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] fast_o
);
  logic [NUM_CH-1:0] en_q, fast_q;
  logic [NUM_CH-1:0] lock_mask;

  always_comb begin
    lock_mask = '0;
    lock_mask[LOCKED_CH-1:0] = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= lock_mask;
      fast_q <= lock_mask;
    end else begin
      for (int w = 0; w < BIT_WORDS; w++) begin
        if (int'(word_sel) == w) begin
          if (set_we)
            en_q[w*DATA_W +: DATA_W] <= en_q[w*DATA_W +: DATA_W] | wr_data;
          else if (clr_we)
            en_q[w*DATA_W +: DATA_W] <= en_q[w*DATA_W +: DATA_W] &
                                        ~(wr_data & ~lock_mask[w*DATA_W +: DATA_W]);
          if (fast_we)
            fast_q[w*DATA_W +: DATA_W] <= wr_data;
        end
      end
    end
  end

  assign en_o   = en_q;
  assign fast_o = fast_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_CH = 96,
  localparam int IDX_W = $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH-1:0] hit_i,
  output logic [IDX_W-1:0]  idx_o
);
  // Lowest channel wins; result is channel+1, 0 when none
  always_comb begin
    idx_o = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (hit_i[c]) idx_o = IDX_W'(c + 1);
  end
endmodule

// File: rtl/irq_vector_mgr.sv
module irq_vector_mgr
  import irq_vector_mgr_pkg::*;
#(
  parameter int NUM_CH  = 96,
  parameter int NUM_REQ = 96,
  parameter int REQ_W   = 7,
  localparam int MAP_WORDS = NUM_CH / LANES,
  localparam int MW_W      = $clog2(MAP_WORDS),
  localparam int BIT_WORDS = NUM_CH / DATA_W,
  localparam int IDX_W     = $clog2(NUM_CH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  reg_grp_e          grp;
  logic [DATA_W-1:0] map_rd, rd_mux;
  logic [NUM_CH-1:0] pend, en, fast, norm_hit, fast_hit;
  logic [IDX_W-1:0]  idx_next, idx_q;
  logic              word_ok;

  assign grp     = decode_grp(reg_addr, MAP_WORDS);
  assign word_ok = int'(reg_addr[1:0]) < BIT_WORDS;

  irq_map_table #(.NUM_CH(NUM_CH), .NUM_REQ(NUM_REQ), .REQ_W(REQ_W)) u_map (
    .clk(clk), .rst(rst),
    .wr_en(reg_we && grp == GRP_MAP),
    .word_sel(reg_addr[MW_W-1:0]),
    .wr_data(reg_wdata), .req_i(req_i),
    .rd_data(map_rd), .pend_o(pend)
  );

  irq_mask_bank #(.NUM_CH(NUM_CH)) u_mask (
    .clk(clk), .rst(rst),
    .set_we(reg_we && grp == GRP_ENSET && word_ok),
    .clr_we(reg_we && grp == GRP_ENCLR && word_ok),
    .fast_we(reg_we && grp == GRP_FAST && word_ok),
    .word_sel(reg_addr[1:0]), .wr_data(reg_wdata),
    .en_o(en), .fast_o(fast)
  );

  assign norm_hit = pend & en & ~fast;
  assign fast_hit = pend & en & fast;

  irq_prio_pick #(.NUM_CH(NUM_CH)) u_pick (.hit_i(norm_hit), .idx_o(idx_next));

  always_comb begin
    rd_mux = '0;
    unique case (grp)
      GRP_MAP:             rd_mux = map_rd;
      GRP_ENSET, GRP_ENCLR: if (word_ok) rd_mux = en[int'(reg_addr[1:0])*DATA_W +: DATA_W];
      GRP_FAST:            if (word_ok) rd_mux = fast[int'(reg_addr[1:0])*DATA_W +: DATA_W];
      GRP_PEND:            if (word_ok) rd_mux = pend[int'(reg_addr[1:0])*DATA_W +: DATA_W];
      GRP_INDEX:           rd_mux = DATA_W'(idx_q);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      idx_q     <= idx_next;
      irq_o     <= |norm_hit;
      fiq_o     <= |fast_hit;
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_vector_mgr_chk.sv
module irq_vector_mgr_chk #(
  parameter int NUM_CH = 96,
  localparam int IDX_W = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [6:0]        reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [IDX_W-1:0]  idx_q,
  input logic [NUM_CH-1:0] en,
  input logic [NUM_CH-1:0] fast,
  input logic [NUM_CH-1:0] pend
);
  a_r8_irq_tracks_index: assert property (@(posedge clk) disable iff (rst)
    irq_o == (idx_q != '0));

  a_r7_index_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(idx_q) <= NUM_CH);

  a_r5_locked_enabled: assert property (@(posedge clk) disable iff (rst)
    en[1:0] == 2'b11);

  a_r9_fast_output: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fiq_o == $past(|(pend & en & fast)));

  a_r3_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 7'h20) |=> ((en[31:0] & $past(reg_wdata)) == $past(reg_wdata)));

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 7'h24) |=> ((en[31:2] & $past(reg_wdata[31:2])) == '0));
endmodule

bind irq_vector_mgr irq_vector_mgr_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .fiq_o(fiq_o), .idx_q(idx_q),
  .en(en), .fast(fast), .pend(pend)
);

// File: tb/irq_vector_mgr_bench.sv
module irq_vector_mgr_bench;
  localparam int NR = 96;
  logic clk = 1'b0, rst = 1'b1;
  logic [NR-1:0] req_i = '0;
  logic [6:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, fiq_o;
  int n_chk = 0, n_err = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;  // 50 MHz

  irq_vector_mgr u_irq_vector_mgr (
    .clk(clk), .rst(rst), .req_i(req_i), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  localparam int NV = 8;
  localparam logic [NR-1:0] V_REQ [NV] = '{
    96'h0, 96'h20, (96'h1 << 40) | 96'h20, 96'h1 << 95,
    96'h1, (96'h1 << 63) | 96'h2, 96'h4, (96'h1 << 31) | (96'h1 << 32)};
  localparam logic [31:0] V_IDX [NV] = '{0, 6, 6, 96, 0, 64, 3, 32};
  localparam logic V_FIQ [NV] = '{0, 0, 0, 0, 1, 1, 0, 0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Holds the address for three edges so index, rdata and outputs have settled
  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // Reset state
    rd(7'h00, rv); chk("R1 map word0 reset", rv, 32'h00010203);
    rd(7'h05, rv); chk("R1 map word5 reset", rv, 32'h14151617);
    rd(7'h28, rv); chk("R6 fast word0 reset", rv, 32'h3);
    rd(7'h20, rv); chk("R5 locked enables at reset", rv, 32'h3);
    rd(7'h21, rv); chk("R3 enable word1 reset", rv, 32'h0);
    rd(7'h30, rv); chk("R7 index reset", rv, 32'h0);
    chk("R8 irq reset", {31'b0, irq_o}, 32'h0);

    // Enable all channels
    for (int w = 0; w < 3; w++) wr(7'h20 + 7'(w), 32'hFFFF_FFFF);
    rd(7'h26, rv); chk("R4 enable read via clear addr", rv, 32'hFFFF_FFFF);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      req_i = V_REQ[i];
      rd(7'h30, rv);
      chk($sformatf("R7 table index v%0d", i), rv, V_IDX[i]);
      chk($sformatf("R8 table irq v%0d", i), {31'b0, irq_o}, {31'b0, V_IDX[i] != 0});
      chk($sformatf("R9 table fiq v%0d", i), {31'b0, fiq_o}, {31'b0, V_FIQ[i]});
    end

    // Remap channel 2 to request 70; bit 31 of the write is dropped
    wr(7'h00, 32'h8001_4603);
    rd(7'h00, rv); chk("R1 map readback drops unused bits", rv, 32'h0001_4603);
    req_i = 96'h1 << 70;
    rd(7'h2C, rv); chk("R2 pending word0 after remap", rv, 32'h4);
    rd(7'h2E, rv); chk("R2 pending word2 channel 70", rv, 32'h40);
    rd(7'h30, rv); chk("R7 remapped channel wins", rv, 32'd3);
    // Channel 3 to out-of-range request 100
    wr(7'h00, 32'h0001_4664);
    req_i = '1;
    rd(7'h2C, rv); chk("R2 out-of-range map not pending", rv, 32'hFFFF_FFF7);
    wr(7'h00, 32'h0001_0203);

    // Clear cannot touch channels 0/1
    wr(7'h24, 32'hFFFF_FFFF);
    rd(7'h20, rv); chk("R5 clear leaves locked channels", rv, 32'h3);
    req_i = 96'h1;
    rd(7'h30, rv); chk("R9 fiq from locked channel", {31'b0, fiq_o}, 32'h1);
    req_i = 96'h20;
    rd(7'h30, rv); chk("R4 cleared channel ignored", rv, 32'h0);
    chk("R8 irq low when idle", {31'b0, irq_o}, 32'h0);

    // Make channel 4 fast-class
    wr(7'h20, 32'hFFFF_FFFF);
    wr(7'h28, 32'h13);
    rd(7'h28, rv); chk("R6 fast select write", rv, 32'h13);
    req_i = 96'h10;
    rd(7'h30, rv); chk("R6 fast channel skipped", rv, 32'h0);
    chk("R9 fiq from fast channel", {31'b0, fiq_o}, 32'h1);
    req_i = 96'h90;
    rd(7'h30, rv); chk("R6 next normal channel wins", rv, 32'd8);
    rd(7'h30, rv); chk("R10 repeated index read", rv, 32'd8);
    rd(7'h2C, rv); chk("R10 pending unchanged by reads", rv, 32'h90);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule